// File: doc/BRIEF.md
# Active Tamper Pattern Generator and Checker

This block drives pseudo-random bit patterns out to a set of tamper loops and watches the bits that come back. Each transmitter owns a 16-bit linear feedback shift register with a programmable feedback polynomial and start value. The register advances at one of four slow rates, and each rate is a power-of-two multiple of a base number of RTC ticks. The most significant bit of the register is the transmitted bit.

Each receiver is bound to one transmitter. It compares the bit that returns from the loop with the bit that transmitter is currently sending. A broken or probed loop therefore shows up as a mismatch. In unfiltered mode the receiver samples once per step, at the midpoint of the step period. In filtered mode a mismatch must persist over several consecutive RTC ticks before the receiver reports it. Detections latch into sticky per-receiver status bits. Flags from the environmental sensors arrive already detected, and they latch into their own sticky status bits.

Top module: `tamper_lfsr_mon`

## Requirements
- R1: While reset is low and just after it is released, every `status` and `env_status` bit is 0 and every `tx_out` bit is 0.
- R2: On each step of an enabled transmitter, its register shifts left by one and takes a 0 in bit 0. If the bit shifted out of bit 15 was 1, the register is also XORed with that transmitter's polynomial. `tx_out` is bit 15 of the register.
- R3: While a transmitter's `tx_en` bit is 0, its register is loaded on every clock with its seed, or with 1 when the seed is 0, and its tick counter is cleared to 0.
- R4: The step period in ticks is `STEP0 << rate`, where `rate` is a transmitter's 2-bit field. Code 0 gives the shortest period and code 3 gives the longest, eight times the shortest. `tx_out` changes only on a clock where `rtc_tick` was high.
- R5: A receiver's 3-bit `rx_sel` field set to a code from 1 to 5 binds the receiver to transmitter code-1. Any other code binds it to transmitter 0.
- R6: With its filter off, an enabled receiver compares `rx_in` with the bound `tx_out` only on the tick that completes half of the bound transmitter's step period, counting from the last step or from enable. A difference on that tick sets its status bit.
- R7: With its filter on and a filter value F, an enabled receiver counts consecutive ticks on which `rx_in` differs from the bound `tx_out`. The status bit sets on the (F+1)-th such tick. A tick on which the two bits agree resets the count.
- R8: Status bits are sticky. A 1 on a bit of `status_clr` clears that bit at the next clock edge. When a set and a clear fall on the same edge, the set wins.
- R9: A receiver whose `rx_en` bit is 0 never sets its status bit, and its filter count is held at 0.
- R10: Each `env_flag` bit that is high sets the matching sticky `env_status` bit. A 1 on `env_clr` clears that bit, and a set on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_tick | input | 1 | One-clock pulse per RTC base tick |
| tx_en | input | NTX | Per-transmitter run enable |
| tx_poly | input | NTX*16 | Feedback polynomials, transmitter t at bits [16t+15:16t] |
| tx_seed | input | NTX*16 | Start values, same packing as tx_poly |
| tx_rate | input | NTX*2 | Step rate codes, transmitter t at bits [2t+1:2t] |
| tx_out | output | NTX | Transmitted pattern bits |
| rx_en | input | NRX | Per-receiver enable |
| rx_sel | input | NRX*3 | Bound transmitter codes, receiver r at bits [3r+2:3r] |
| rx_filt_en | input | NRX | Per-receiver filter enable |
| rx_filt | input | NRX*8 | Filter values, receiver r at bits [8r+7:8r] |
| rx_in | input | NRX | Returned loop bits |
| status_clr | input | NRX | Per-receiver status clear pulses |
| status | output | NRX | Sticky tamper detection bits |
| env_flag | input | NENV | Detected sensor flags |
| env_clr | input | NENV | Per-flag clear pulses |
| env_status | output | NENV | Sticky sensor status bits |

## Verification
The hardest case to reach is a mismatch that lands exactly on the midpoint sampling tick of the bound transmitter, together with a reconfiguration that moves a running counter past a shorter new period. Random phases change rates, bindings (invalid codes included), seeds and filter values while transmitters keep running. The bench drives each returned bit from its own model of the bound pattern and flips it at random, so mismatches hit both sampled and unsampled ticks. Directed sequences hold a mismatch for exactly F and then F+1 ticks, and run a zero seed with a zero polynomial up to the step where bit 15 first goes high.

// File: rtl/tamper_lfsr_mon.sv
module tamper_lfsr_mon #(
  parameter int NTX   = 5,
  parameter int NRX   = 4,
  parameter int NENV  = 3,
  parameter int LW    = 16,
  parameter int FW    = 8,
  parameter int STEP0 = 4,
  parameter int SW    = $clog2(NTX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_tick,
  input  logic [NTX-1:0]    tx_en,
  input  logic [NTX*LW-1:0] tx_poly,
  input  logic [NTX*LW-1:0] tx_seed,
  input  logic [NTX*2-1:0]  tx_rate,
  output logic [NTX-1:0]    tx_out,
  input  logic [NRX-1:0]    rx_en,
  input  logic [NRX*SW-1:0] rx_sel,
  input  logic [NRX-1:0]    rx_filt_en,
  input  logic [NRX*FW-1:0] rx_filt,
  input  logic [NRX-1:0]    rx_in,
  input  logic [NRX-1:0]    status_clr,
  output logic [NRX-1:0]    status,
  input  logic [NENV-1:0]   env_flag,
  input  logic [NENV-1:0]   env_clr,
  output logic [NENV-1:0]   env_status
);
  localparam int CW = $clog2(STEP0 * 8);

  logic [NTX-1:0] half;
  logic [NRX-1:0] set_now;

  for (genvar t = 0; t < NTX; t++) begin : g_tx
    logic [LW-1:0] lfsr;
    logic [CW-1:0] cnt;
    logic [LW-1:0] poly, seed;
    logic [CW:0]   per;
    logic          step;

    assign poly = tx_poly[t*LW +: LW];
    assign seed = (tx_seed[t*LW +: LW] == '0) ? LW'(1) : tx_seed[t*LW +: LW];
    assign per  = (CW+1)'(STEP0) << tx_rate[2*t +: 2];
    assign step = ({1'b0, cnt} >= per - (CW+1)'(1));
    assign half[t] = rtc_tick && ({1'b0, cnt} == (per >> 1) - (CW+1)'(1));
    assign tx_out[t] = lfsr[LW-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lfsr <= LW'(1);
        cnt  <= '0;
      end else if (!tx_en[t]) begin
        lfsr <= seed;
        cnt  <= '0;
      end else if (rtc_tick) begin
        if (step) begin
          cnt  <= '0;
          lfsr <= {lfsr[LW-2:0], 1'b0} ^ (lfsr[LW-1] ? poly : '0);
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en[t] && !rtc_tick) |=> $stable(tx_out[t]));
  end

  for (genvar r = 0; r < NRX; r++) begin : g_rx
    logic [SW-1:0] code;
    logic [FW-1:0] filt, mc;
    logic          exp_bit, strobe, miss;

    assign code = rx_sel[r*SW +: SW];
    assign filt = rx_filt[r*FW +: FW];

    always_comb begin
      exp_bit = tx_out[0];
      strobe  = half[0];
      for (int k = 1; k < NTX; k++)
        if (code == SW'(k + 1)) begin
          exp_bit = tx_out[k];
          strobe  = half[k];
        end
    end

    assign miss = rx_in[r] ^ exp_bit;
    assign set_now[r] = rx_en[r] &&
      (rx_filt_en[r] ? (rtc_tick && miss && mc == filt) : (strobe && miss));

    always_ff @(posedge clk) begin
      if (!rst_n || !rx_en[r] || !rx_filt_en[r]) mc <= '0;
      else if (rtc_tick) mc <= !miss ? '0 : (mc == filt ? mc : mc + FW'(1));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) status[r] <= 1'b0;
      else if (set_now[r]) status[r] <= 1'b1;
      else if (status_clr[r]) status[r] <= 1'b0;
    end

    assert_enabled_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[r]) |-> $past(rx_en[r]));
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status[r] && !status_clr[r]) |=> status[r]);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_clr[r] && !set_now[r]) |=> !status[r]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) env_status <= '0;
    else env_status <= (env_status & ~env_clr) | env_flag;
  end

  for (genvar e = 0; e < NENV; e++) begin : g_env
    assert_env_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (env_status[e] && !env_clr[e]) |=> env_status[e]);
    assert_env_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      env_flag[e] |=> env_status[e]);
  end
endmodule

// File: tb/sim_tamper_lfsr_mon.sv
module sim_tamper_lfsr_mon;
  localparam int NTX = 5, NRX = 4, NENV = 3, LW = 16, FW = 8, STEP0 = 4, SW = 3;

  logic clk = 0, rst_n = 0, rtc_tick = 0;
  logic [NTX-1:0] tx_en = '0, tx_out;
  logic [NTX*LW-1:0] tx_poly = '0, tx_seed = '0;
  logic [NTX*2-1:0] tx_rate = '0;
  logic [NRX-1:0] rx_en = '0, rx_filt_en = '0, rx_in = '0, status_clr = '0, status;
  logic [NRX*SW-1:0] rx_sel = '0;
  logic [NRX*FW-1:0] rx_filt = '0;
  logic [NENV-1:0] env_flag = '0, env_clr = '0, env_status;

  tamper_lfsr_mon u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [LW-1:0] m_l [NTX];
  int            m_c [NTX];
  int            m_mc [NRX];
  logic [NRX-1:0]  m_st;
  logic [NENV-1:0] m_env;
  int flip_rate = 30, tick_rate = 2;
  logic [NRX-1:0] force_miss = '0;

  function automatic int per_of(int t);
    return STEP0 << tx_rate[2*t +: 2];
  endfunction

  function automatic int bound(int r);
    int c = int'(rx_sel[r*SW +: SW]);
    return (c >= 1 && c <= NTX) ? c - 1 : 0;
  endfunction

  function automatic logic [LW-1:0] seed_of(int t);
    return (tx_seed[t*LW +: LW] == '0) ? LW'(1) : tx_seed[t*LW +: LW];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [NRX-1:0] nst;
    nst = m_st;
    for (int r = 0; r < NRX; r++) begin
      int b = bound(r);
      logic miss = rx_in[r] ^ m_l[b][LW-1];
      logic setb = 0;
      if (rx_en[r]) begin
        if (rx_filt_en[r]) setb = rtc_tick && miss && (m_mc[r] == int'(rx_filt[r*FW +: FW]));
        else setb = rtc_tick && miss && (m_c[b] == per_of(b)/2 - 1);
      end
      if (!rx_en[r] || !rx_filt_en[r]) m_mc[r] = 0;
      else if (rtc_tick) m_mc[r] = !miss ? 0 :
        (m_mc[r] == int'(rx_filt[r*FW +: FW]) ? m_mc[r] : m_mc[r] + 1);
      if (setb) nst[r] = 1;
      else if (status_clr[r]) nst[r] = 0;
    end
    m_st = nst;
    for (int t = 0; t < NTX; t++) begin
      if (!tx_en[t]) begin
        m_l[t] = seed_of(t);
        m_c[t] = 0;
      end else if (rtc_tick) begin
        if (m_c[t] >= per_of(t) - 1) begin
          m_c[t] = 0;
          m_l[t] = {m_l[t][LW-2:0], 1'b0} ^ (m_l[t][LW-1] ? tx_poly[t*LW +: LW] : '0);
        end else m_c[t]++;
      end
    end
    m_env = (m_env & ~env_clr) | env_flag;
  endtask

  function automatic logic [NTX-1:0] m_tx();
    logic [NTX-1:0] v;
    for (int t = 0; t < NTX; t++) v[t] = m_l[t][LW-1];
    return v;
  endfunction

  // one clock: drive at negedge, update model and compare after the edge
  task automatic cyc(bit randomize);
    rtc_tick = ($urandom % tick_rate) == 0;
    for (int r = 0; r < NRX; r++) begin
      logic e = m_l[bound(r)][LW-1];
      rx_in[r] = force_miss[r] ? ~e : (randomize && ($urandom % flip_rate == 0) ? ~e : e);
      status_clr[r] = randomize && ($urandom % 40 == 0);
    end
    for (int e = 0; e < NENV; e++) begin
      env_flag[e] = randomize && ($urandom % 60 == 0);
      env_clr[e]  = randomize && ($urandom % 25 == 0);
    end
    @(posedge clk);
    #1;
    model_update();
    chk("R2 R3 R4 tx_out", 32'(tx_out), 32'(m_tx()));
    chk("R5 R6 R7 R8 R9 status", 32'(status), 32'(m_st));
    chk("R10 env_status", 32'(env_status), 32'(m_env));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h7A3E_0115));
    for (int t = 0; t < NTX; t++) begin m_l[t] = LW'(1); m_c[t] = 0; end
    for (int r = 0; r < NRX; r++) m_mc[r] = 0;
    m_st = '0; m_env = '0;

    repeat (3) @(negedge clk);
    chk("R1 reset status", 32'(status), 0);
    chk("R1 reset env_status", 32'(env_status), 0);
    chk("R1 reset tx_out", 32'(tx_out), 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 status after release", 32'(status), 0);
    chk("R1 tx_out after release", 32'(tx_out), 0);
    // model mirrors the disabled-transmitter seed load on that edge
    for (int t = 0; t < NTX; t++) m_l[t] = seed_of(t);
    @(negedge clk);

    // R3: zero seed with zero polynomial becomes 1; bit 15 first rises after 15 steps
    tick_rate = 1;
    tx_en = 5'b00001;
    for (int i = 0; i < 59; i++) cyc(0);
    chk("R3 zero seed, 59 ticks", 32'(tx_out[0]), 0);
    cyc(0);
    chk("R3 zero seed, 60 ticks", 32'(tx_out[0]), 1);

    // R7: filter value 3, mismatch for 3 ticks does not set, for 4 ticks does
    tx_en = '0; cyc(0);
    tx_seed[0 +: LW] = 16'hB5A3; tx_poly[0 +: LW] = 16'h1021;
    rx_en = 4'b0001; rx_filt_en = 4'b0001; rx_filt[0 +: FW] = 8'd3; rx_sel[0 +: SW] = 3'd1;
    tx_en = 5'b00001;
    repeat (5) cyc(0);
    force_miss = 4'b0001;
    repeat (3) cyc(0);
    force_miss = '0;
    cyc(0);
    chk("R7 three mismatched ticks", 32'(status[0]), 0);
    force_miss = 4'b0001;
    repeat (3) cyc(0);
    chk("R7 before fourth tick", 32'(status[0]), 0);
    cyc(0);
    chk("R7 fourth mismatched tick", 32'(status[0]), 1);
    force_miss = '0;
    status_clr = 4'b0001; rtc_tick = 0;
    @(posedge clk); #1; model_update();
    chk("R8 clear", 32'(status[0]), 0);
    @(negedge clk); status_clr = '0;

    // R9: disabled receiver with permanent mismatch stays clear
    rx_en = '0; force_miss = 4'b0001;
    repeat (40) cyc(0);
    chk("R9 disabled receiver", 32'(status[0]), 0);
    force_miss = '0;

    // random phases
    for (int ph = 0; ph < 20; ph++) begin
      tick_rate = 1 + $urandom % 3;
      flip_rate = 10 + $urandom % 60;
      for (int t = 0; t < NTX; t++) begin
        tx_en[t] = ($urandom % 5) != 0;
        tx_poly[t*LW +: LW] = LW'($urandom);
        tx_seed[t*LW +: LW] = ($urandom % 6 == 0) ? '0 : LW'($urandom);
        tx_rate[2*t +: 2] = 2'($urandom);
      end
      for (int r = 0; r < NRX; r++) begin
        rx_en[r] = ($urandom % 6) != 0;
        rx_sel[r*SW +: SW] = 3'($urandom);
        rx_filt_en[r] = $urandom % 2;
        rx_filt[r*FW +: FW] = 8'($urandom % 6);
      end
      repeat (3000) cyc(1);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule